// File: doc/BRIEF.md
# Reset Recovery Sequencer with Vector Selection

This block governs how a processor core comes out of reset. It accepts four reset causes: a power-on pulse, a clock-failure pulse, a watchdog expiry pulse, and an outside agent pulling the shared open-drain reset line low. For any cause it pulls that line low. For power-on and clock failure it first waits out an oscillator settling interval. It then runs a fixed low phase, lets go of the line, and reads the line back a set number of cycles later. This tells whether something outside is still holding reset.

From that reading and from two latched cause flags it loads the address the core fetches first: the clock-failure entry, the watchdog entry or the ordinary start entry. It then releases the core. If an outside agent still holds the line at the read-back point, the block treats the event as external. It drops both flags and keeps the core in reset until the line comes back high. The line input passes through a synchronizer before any decision uses it. A new cause at any moment restarts the whole sequence.

Top module: `reset_recovery_top`

## Requirements
- R1: While `por_in` is high, `pin_drive_low` and `core_rst` are 1, both cause flags are cleared, and `vec_addr` reads 0xFFFE.
- R2: After a one-cycle `por_in` or `clkfail_in` pulse, `pin_drive_low` stays 1 for OSC_WAIT + LOW_CYC cycles (4096 + 16 = 4112 with defaults).
- R3: After a one-cycle `wdog_in` pulse, or an external low request, `pin_drive_low` stays 1 for exactly LOW_CYC (16) cycles.
- R4: After the drive ends, `pin_in` is synchronized through two flops and read on the SAMPLE_DLY-th (9th) cycle. If it reads high, `core_rst` falls on the clock edge that ends that cycle, which is 9 cycles after `pin_drive_low` falls.
- R5: If the line still reads low at the read-back point, both cause flags are cleared, 0xFFFE is loaded, and `core_rst` stays 1 until the synchronized line reads high.
- R6: With the line high at read-back and the clock-failure flag set, 0xFFFC is loaded, whether or not the watchdog flag is also set.
- R7: With the line high at read-back, the clock-failure flag clear and the watchdog flag set, 0xFFFA is loaded. Both flags are cleared at every read-back decision, so a later watchdog-only reset yields 0xFFFA even after an earlier clock failure.
- R8: A new cause pulse arriving during the sequence restarts it. A watchdog pulse in the release window gives a fresh 16-cycle drive and only one completion.
- R9: While the core runs, a synchronized low on `pin_in` starts a recovery sequence with no oscillator wait.
- R10: `pin_drive_low` is never 1 while `core_rst` is 0, and `vec_addr` does not change while `core_rst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_in | input | 1 | Power-on pulse, also synchronous active-high reset |
| clkfail_in | input | 1 | Clock-failure cause pulse |
| wdog_in | input | 1 | Watchdog expiry pulse |
| pin_in | input | 1 | Level read back from the shared reset line |
| pin_drive_low | output | 1 | Enables the open-drain pull-down on the reset line |
| core_rst | output | 1 | Holds the core in reset while 1 |
| vec_addr | output | 16 | Start address the core fetches when released |

## Verification
The bench tries the main function with each cause on its own: power-on, clock failure, watchdog, and an outside low on the line. The measured drive length separates the causes that include the settling wait from those that do not. The vector returned separates the three priority outcomes. Combined patterns then check ordering rules. A clock failure together with a watchdog must still pick 0xFFFC. A watchdog followed by an outside hold must fall back to 0xFFFE. A second watchdog in the release window must restart the sequence rather than finish it. A watchdog after a clock failure shows that the flags were cleared at the previous decision.

// File: rtl/rrv_pkg.sv
package rrv_pkg;
  typedef enum logic [2:0] {
    ST_OSC  = 3'd0,
    ST_LOW  = 3'd1,
    ST_REL  = 3'd2,
    ST_HOLD = 3'd3,
    ST_RUN  = 3'd4
  } rr_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/rr_sync.sv
module rr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rr_cause_latch.sv
module rr_cause_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_cm,
  input  logic set_wd,
  input  logic clr,
  output logic cm_q,
  output logic wd_q
);
  // a fresh cause wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      cm_q <= 1'b0;
      wd_q <= 1'b0;
    end else begin
      if (set_cm)   cm_q <= 1'b1;
      else if (clr) cm_q <= 1'b0;
      if (set_wd)   wd_q <= 1'b1;
      else if (clr) wd_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rr_seq_fsm.sv
module rr_seq_fsm
  import rrv_pkg::*;
#(
  parameter int OSC_WAIT   = 4096,
  parameter int LOW_CYC    = 16,
  parameter int SAMPLE_DLY = 9
) (
  input  logic clk,
  input  logic por,
  input  logic cm_evt,
  input  logic wd_evt,
  input  logic pin_s,
  output logic drive_low,
  output logic core_rst,
  output logic load_pri,
  output logic load_norm
);
  localparam int CNT_MAX = max3(OSC_WAIT, LOW_CYC, SAMPLE_DLY);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] OSC_LAST = CNT_W'(OSC_WAIT - 1);
  localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(SAMPLE_DLY - 1);

  rr_state_e        state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             ext_req, new_cause, at_sample;

  assign ext_req   = (state == ST_RUN) && !pin_s;
  assign new_cause = cm_evt || wd_evt;
  assign at_sample = (state == ST_REL) && (cnt == REL_LAST) && !new_cause;
  assign load_pri  = at_sample && pin_s;
  assign load_norm = at_sample && !pin_s;

  always_comb begin
    state_n = state;
    cnt_n   = cnt + 1'b1;
    if (cm_evt) begin
      state_n = ST_OSC;
      cnt_n   = '0;
    end else if (wd_evt) begin
      state_n = ST_LOW;
      cnt_n   = '0;
    end else begin
      case (state)
        ST_OSC: if (cnt == OSC_LAST) begin
          state_n = ST_LOW;
          cnt_n   = '0;
        end
        ST_LOW: if (cnt == LOW_LAST) begin
          state_n = ST_REL;
          cnt_n   = '0;
        end
        ST_REL: if (cnt == REL_LAST) begin
          state_n = pin_s ? ST_RUN : ST_HOLD;
          cnt_n   = '0;
        end
        ST_HOLD: begin
          cnt_n = '0;
          if (pin_s) state_n = ST_RUN;
        end
        ST_RUN: begin
          cnt_n = '0;
          if (ext_req) state_n = ST_LOW;
        end
        default: begin
          state_n = ST_OSC;
          cnt_n   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      state     <= ST_OSC;
      cnt       <= '0;
      drive_low <= 1'b1;
      core_rst  <= 1'b1;
    end else begin
      state     <= state_n;
      cnt       <= cnt_n;
      drive_low <= (state_n == ST_OSC) || (state_n == ST_LOW);
      core_rst  <= (state_n != ST_RUN);
    end
  end
endmodule

// File: rtl/rr_vec_sel.sv
module rr_vec_sel #(
  parameter int               VEC_W  = 16,
  parameter logic [VEC_W-1:0] V_NORM = 16'hFFFE,
  parameter logic [VEC_W-1:0] V_CM   = 16'hFFFC,
  parameter logic [VEC_W-1:0] V_WD   = 16'hFFFA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cm,
  input  logic             wd,
  input  logic             load_pri,
  input  logic             load_norm,
  output logic [VEC_W-1:0] vec
);
  logic [VEC_W-1:0] pick;

  always_comb begin
    if (cm)      pick = V_CM;
    else if (wd) pick = V_WD;
    else         pick = V_NORM;
  end

  always_ff @(posedge clk) begin
    if (rst)            vec <= V_NORM;
    else if (load_pri)  vec <= pick;
    else if (load_norm) vec <= V_NORM;
  end
endmodule

// File: rtl/reset_recovery_top.sv
module reset_recovery_top #(
  parameter int               OSC_WAIT    = 4096,
  parameter int               LOW_CYC     = 16,
  parameter int               SAMPLE_DLY  = 9,
  parameter int               SYNC_STAGES = 2,
  parameter int               VEC_W       = 16,
  parameter logic [VEC_W-1:0] V_NORM      = 16'hFFFE,
  parameter logic [VEC_W-1:0] V_CM        = 16'hFFFC,
  parameter logic [VEC_W-1:0] V_WD        = 16'hFFFA
) (
  input  logic             clk,
  input  logic             por_in,
  input  logic             clkfail_in,
  input  logic             wdog_in,
  input  logic             pin_in,
  output logic             pin_drive_low,
  output logic             core_rst,
  output logic [VEC_W-1:0] vec_addr
);
  logic pin_s, cm_q, wd_q, load_pri, load_norm;

  rr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(por_in), .d(pin_in), .q(pin_s)
  );

  rr_cause_latch u_flags (
    .clk(clk), .rst(por_in), .set_cm(clkfail_in), .set_wd(wdog_in),
    .clr(load_pri | load_norm), .cm_q(cm_q), .wd_q(wd_q)
  );

  rr_seq_fsm #(.OSC_WAIT(OSC_WAIT), .LOW_CYC(LOW_CYC), .SAMPLE_DLY(SAMPLE_DLY)) u_fsm (
    .clk(clk), .por(por_in), .cm_evt(clkfail_in), .wd_evt(wdog_in), .pin_s(pin_s),
    .drive_low(pin_drive_low), .core_rst(core_rst),
    .load_pri(load_pri), .load_norm(load_norm)
  );

  rr_vec_sel #(.VEC_W(VEC_W), .V_NORM(V_NORM), .V_CM(V_CM), .V_WD(V_WD)) u_vec (
    .clk(clk), .rst(por_in), .cm(cm_q), .wd(wd_q),
    .load_pri(load_pri), .load_norm(load_norm), .vec(vec_addr)
  );
endmodule

// File: rtl/reset_recovery_checker.sv
module reset_recovery_checker #(
  parameter int               VEC_W  = 16,
  parameter logic [VEC_W-1:0] V_NORM = 16'hFFFE,
  parameter logic [VEC_W-1:0] V_CM   = 16'hFFFC,
  parameter logic [VEC_W-1:0] V_WD   = 16'hFFFA
) (
  input logic             clk,
  input logic             por_in,
  input logic             clkfail_in,
  input logic             wdog_in,
  input logic             pin_drive_low,
  input logic             core_rst,
  input logic [VEC_W-1:0] vec_addr
);
  assert_por_hold_R1: assert property (@(posedge clk)
    por_in |=> (pin_drive_low && core_rst && vec_addr == V_NORM));

  assert_cause_drives_R2: assert property (@(posedge clk) disable iff (por_in)
    clkfail_in |=> (pin_drive_low && core_rst));

  assert_wdog_drives_R3: assert property (@(posedge clk) disable iff (por_in)
    wdog_in |=> (pin_drive_low && core_rst));

  assert_release_first_R4: assert property (@(posedge clk) disable iff (por_in)
    $fell(pin_drive_low) |-> core_rst);

  assert_vec_legal_R6: assert property (@(posedge clk) disable iff (por_in)
    (vec_addr == V_NORM) || (vec_addr == V_CM) || (vec_addr == V_WD));

  assert_drive_in_reset_R10: assert property (@(posedge clk) disable iff (por_in)
    pin_drive_low |-> core_rst);

  assert_vec_stable_R10: assert property (@(posedge clk) disable iff (por_in)
    (!core_rst && $past(!core_rst)) |-> $stable(vec_addr));
endmodule

bind reset_recovery_top reset_recovery_checker #(
  .VEC_W(VEC_W), .V_NORM(V_NORM), .V_CM(V_CM), .V_WD(V_WD)
) u_chk (
  .clk(clk), .por_in(por_in), .clkfail_in(clkfail_in), .wdog_in(wdog_in),
  .pin_drive_low(pin_drive_low), .core_rst(core_rst), .vec_addr(vec_addr)
);

// File: tb/tb_reset_recovery_top.sv
`timescale 1ns/1ps
module tb_reset_recovery_top;
  logic        clk = 1'b0;
  logic        por_in = 1'b1;
  logic        clkfail_in = 1'b0;
  logic        wdog_in = 1'b0;
  logic        ext_hold = 1'b0;
  logic        pin_in;
  logic        pin_drive_low, core_rst;
  logic [15:0] vec_addr;

  always #4 clk = ~clk;

  // wired reset line with pull-up: low if the block or the outside pulls it
  assign pin_in = !(pin_drive_low === 1'b1) && !ext_hold;

  reset_recovery_top dut (
    .clk(clk), .por_in(por_in), .clkfail_in(clkfail_in), .wdog_in(wdog_in),
    .pin_in(pin_in), .pin_drive_low(pin_drive_low), .core_rst(core_rst),
    .vec_addr(vec_addr)
  );

  typedef struct {
    int    vec;
    int    dlen;
    int    gap;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: measures drive length, release gap and vector per completion
  int dcnt = 0, gcnt = 0;
  bit prev_drive = 0, prev_core = 0;
  always @(negedge clk) begin
    if (pin_drive_low === 1'b1) begin
      if (!prev_drive) begin
        dcnt = 0;
        gcnt = 0;
      end
      dcnt++;
    end else if (core_rst === 1'b1) begin
      gcnt++;
    end
    if (prev_core && core_rst === 1'b0) begin
      if (sb.size() == 0) begin
        chk("R10 unexpected release", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " drive length"}, dcnt, e.dlen);
        if (e.gap >= 0) chk("R4 release-to-run gap", gcnt, e.gap);
        chk({e.tag, " vector"}, int'(vec_addr), e.vec);
      end
    end
    prev_drive = (pin_drive_low === 1'b1);
    prev_core  = (core_rst === 1'b1);
  end

  task automatic fire(input bit cf, input bit wd, input bit pr);
    @(negedge clk);
    clkfail_in = cf;
    wdog_in    = wd;
    por_in     = pr;
    @(negedge clk);
    clkfail_in = 1'b0;
    wdog_in    = 1'b0;
    por_in     = 1'b0;
  endtask

  task automatic drain;
    wait (sb.size() == 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic push(input int v, input int d, input int g, input string t);
    exp_t e;
    e.vec = v; e.dlen = d; e.gap = g; e.tag = t;
    sb.push_back(e);
  endtask

  initial begin
    // power-on held for three edges: 4112 + 2 drive cycles
    push(32'hFFFE, 4114, 9, "R1 R2 power-on");
    @(negedge clk);
    chk("R1 drive in reset", int'(pin_drive_low), 1);
    chk("R1 core in reset", int'(core_rst), 1);
    chk("R1 vector in reset", int'(vec_addr), 32'hFFFE);
    @(negedge clk);
    @(negedge clk);
    por_in = 1'b0;
    drain();

    push(32'hFFFA, 16, 9, "R3 R7 watchdog");
    fire(0, 1, 0);
    drain();

    push(32'hFFFC, 4112, 9, "R2 R6 clock fail");
    fire(1, 0, 0);
    drain();

    // flags from the clock failure must be gone
    push(32'hFFFA, 16, 9, "R7 watchdog after clock fail");
    fire(0, 1, 0);
    drain();

    push(32'hFFFC, 4112, 9, "R6 clock fail with watchdog");
    fire(1, 1, 0);
    drain();

    // outside agent pulls the line while the core runs
    push(32'hFFFE, 16, -1, "R9 external request");
    @(negedge clk);
    ext_hold = 1'b1;
    repeat (35) @(negedge clk);
    chk("R5 core held while line low", int'(core_rst), 1);
    chk("R5 drive released while line low", int'(pin_drive_low), 0);
    repeat (5) @(negedge clk);
    ext_hold = 1'b0;
    drain();

    push(32'hFFFE, 16, -1, "R5 watchdog then outside hold");
    fire(0, 1, 0);
    ext_hold = 1'b1;
    repeat (40) @(negedge clk);
    chk("R5 core held after decision", int'(core_rst), 1);
    ext_hold = 1'b0;
    drain();

    push(32'hFFFA, 16, 9, "R8 restart in release window");
    fire(0, 1, 0);
    repeat (20) @(negedge clk);
    chk("R8 in release window", int'(pin_drive_low), 0);
    fire(0, 1, 0);
    drain();

    push(32'hFFFE, 4112, 9, "R1 R2 power-on pulse");
    fire(0, 0, 1);
    drain();
    chk("R10 core running", int'(core_rst), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule